// File: doc/BRIEF.md
# Flash Write Qualification Guard

This block sits between the pins of a parallel NOR-style flash command port and the command state machine behind it. It decides which bus write cycles may reach that state machine. The three active-low strobes (chip enable, write enable, output enable) and a supply-good flag from an external voltage comparator each pass through a two-flop synchronizer. The strobes then pass through a width filter that drops any level held for fewer than `FILT_N` sampled cycles.

A write is qualified while the filtered chip enable and write enable are both low and the filtered output enable is high. It commits when chip enable or write enable, whichever rises first, goes high. On commit the block emits a one-clock accept strobe along with the address and data that were present while the strobes were low. Address and data must stay steady from the falling strobe until three clock cycles after the rising one.

While the supply flag is low, every write is refused and a reset is driven to the downstream command decoder. The same inhibit holds after reset, and after the supply returns, until a qualified high level on chip enable or write enable has been seen. Because of this, a write enable that was already low at power-up cannot commit a command when it first rises.

Top module: `flash_wr_guard`

## Requirements
- R1: A write is accepted only when the filtered strobes show chip enable low, write enable low and output enable high; every other combination of the three levels, held and then released, produces no accept strobe.
- R2: A qualified write commits when the first of chip enable or write enable goes high. `wr_addr_o`/`wr_data_o` then carry the address and data that were present while both strobes were low.
- R3: A strobe level held for fewer than `FILT_N` consecutive sampled cycles is ignored. A short low pulse starts no write, and a short high interruption inside a write does not commit it.
- R4: `wr_valid_o` is high on exactly the (`FILT_N`+3)-th rising clock edge, counting as edge 1 the first edge that samples the rising strobe.
- R5: `wr_valid_o` is exactly one clock wide for each committed write.
- R6: While `supply_ok` is low, no write is accepted and `cmd_rst_o` is high. `cmd_rst_o` rises on the third clock edge after a low `supply_ok` is first sampled, and it is high during reset.
- R7: After `supply_ok` returns high, writes stay refused until a filtered high level on chip enable or write enable has been seen. A write whose strobes were already low when the supply returned is therefore not committed.
- R8: If chip enable and write enable are low and output enable is high when reset is released, the first rise of write enable is not accepted; the next complete write is accepted.
- R9: If output enable goes low, for at least `FILT_N` cycles, during a write, the later rise of write enable commits nothing.
- R10: `wr_valid_o` and `cmd_rst_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable strobe, active low, asynchronous |
| we_n | input | 1 | Write enable strobe, active low, asynchronous |
| oe_n | input | 1 | Output enable strobe, active low, asynchronous |
| supply_ok | input | 1 | High when the supply is above the lockout threshold |
| addr_i | input | AW | Bus address |
| data_i | input | DW | Bus write data |
| wr_valid_o | output | 1 | One-clock accept strobe for a committed write |
| wr_addr_o | output | AW | Address of the last committed write |
| wr_data_o | output | DW | Data of the last committed write |
| cmd_rst_o | output | 1 | Reset to the downstream command decoder |

## Verification
The bench builds the block with `FILT_N`=3 and 8-bit address and data. With a three-cycle filter, pulse widths below, at and above the threshold can all be swept in a few cycles each, so the filter's edge at width 2 versus width 3 is visible for low pulses and for high interruptions alike. All eight strobe combinations are swept. Lockout and power-up are each entered with the strobes already low, so that the release of write enable under inhibit can be shown to commit nothing.

// File: rtl/fwg_pkg.sv
package fwg_pkg;
    localparam int STB_CE  = 0;
    localparam int STB_WE  = 1;
    localparam int STB_OE  = 2;
    localparam int STB_NUM = 3;
    typedef logic [STB_NUM-1:0] stb_vec_t;
endpackage

// File: rtl/fwg_sync.sv
module fwg_sync #(
    parameter int            W       = 1,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d.s1 = d_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.s1 <= RST_VAL;
            st_q.s2 <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.s2;
endmodule

// File: rtl/fwg_filter.sv
module fwg_filter #(
    parameter int N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_i,
    output logic filt_o
);
    localparam int CW = (N < 2) ? 1 : $clog2(N);

    typedef struct packed {
        logic          lvl;
        logic [CW-1:0] cnt;
    } filt_st_t;

    filt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (in_i == st_q.lvl) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == CW'(N - 1)) begin
            st_d.lvl = in_i;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lvl <= 1'b0;
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign filt_o = st_q.lvl;

    // R3: the filtered level only moves to a value the input already had
    assert_filt_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.lvl) |-> ($past(in_i) == st_q.lvl));

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(N - 1));

    generate
        if (N >= 2) begin : g_wide
            // R3: a change needs at least two consecutive samples of the new level
            assert_filt_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
                !$stable(st_q.lvl) |-> ($past(in_i, 2) == st_q.lvl));
        end
    endgenerate
endmodule

// File: rtl/flash_wr_guard.sv
module flash_wr_guard
    import fwg_pkg::*;
#(
    parameter int AW     = 21,
    parameter int DW     = 16,
    parameter int FILT_N = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic          supply_ok,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] data_i,
    output logic          wr_valid_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [DW-1:0] wr_data_o,
    output logic          cmd_rst_o
);
    typedef struct packed {
        logic          inhibit;
        logic          active;
        logic          valid;
        logic          cmd_rst;
        logic [AW-1:0] hold_addr;
        logic [DW-1:0] hold_data;
        logic [AW-1:0] out_addr;
        logic [DW-1:0] out_data;
    } guard_st_t;

    stb_vec_t stb_raw, stb_s, stb_f;
    logic     sup_s;

    assign stb_raw[STB_CE] = ce_n;
    assign stb_raw[STB_WE] = we_n;
    assign stb_raw[STB_OE] = oe_n;

    fwg_sync #(.W(STB_NUM), .RST_VAL('0)) u_stb_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (stb_raw),
        .q_o   (stb_s)
    );

    fwg_sync #(.W(1), .RST_VAL(1'b0)) u_sup_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (supply_ok),
        .q_o   (sup_s)
    );

    generate
        for (genvar g = 0; g < STB_NUM; g++) begin : g_filt
            fwg_filter #(.N(FILT_N)) u_filt (
                .clk    (clk),
                .rst_n  (rst_n),
                .in_i   (stb_s[g]),
                .filt_o (stb_f[g])
            );
        end
    endgenerate

    guard_st_t st_d, st_q;
    logic lockout, wr_cond, strobe_up, commit;

    always_comb begin
        lockout   = !sup_s;
        wr_cond   = !stb_f[STB_CE] && !stb_f[STB_WE] && stb_f[STB_OE];
        strobe_up = stb_f[STB_CE] || stb_f[STB_WE];
        commit    = st_q.active && strobe_up && stb_f[STB_OE] && !lockout;

        st_d         = st_q;
        st_d.valid   = commit;
        st_d.cmd_rst = lockout;
        st_d.active  = wr_cond && !st_q.inhibit && !lockout;

        if (lockout) begin
            st_d.inhibit = 1'b1;
        end else if (strobe_up) begin
            st_d.inhibit = 1'b0;
        end

        if (!stb_s[STB_CE] && !stb_s[STB_WE]) begin
            st_d.hold_addr = addr_i;
            st_d.hold_data = data_i;
        end

        if (commit) begin
            st_d.out_addr = st_q.hold_addr;
            st_d.out_data = st_q.hold_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.inhibit   <= 1'b1;
            st_q.active    <= 1'b0;
            st_q.valid     <= 1'b0;
            st_q.cmd_rst   <= 1'b1;
            st_q.hold_addr <= '0;
            st_q.hold_data <= '0;
            st_q.out_addr  <= '0;
            st_q.out_data  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_valid_o = st_q.valid;
    assign wr_addr_o  = st_q.out_addr;
    assign wr_data_o  = st_q.out_data;
    assign cmd_rst_o  = st_q.cmd_rst;

    assert_valid_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |=> !wr_valid_o);

    assert_valid_excl_rst_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |-> !cmd_rst_o);

    assert_lockout_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sup_s |=> (!wr_valid_o && cmd_rst_o));

    assert_inhibit_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.inhibit |=> !wr_valid_o);

    assert_oe_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_f[STB_OE] |=> !wr_valid_o);
endmodule

// File: tb/flash_wr_guard_tb_top.sv
module flash_wr_guard_tb_top;
    localparam int AW = 8;
    localparam int DW = 8;
    localparam int N  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, supply_ok = 1'b1;
    logic [AW-1:0] addr_i = '0;
    logic [DW-1:0] data_i = '0;
    logic          wr_valid_o, cmd_rst_o;
    logic [AW-1:0] wr_addr_o;
    logic [DW-1:0] wr_data_o;

    flash_wr_guard #(.AW(AW), .DW(DW), .FILT_N(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .supply_ok(supply_ok), .addr_i(addr_i), .data_i(data_i),
        .wr_valid_o(wr_valid_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
        .cmd_rst_o(cmd_rst_o)
    );

    always #10 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    int cyc = 0;
    int pulse_cnt = 0, last_cyc = 0, overlap = 0, wide = 0;
    logic [AW-1:0] last_addr = '0;
    logic [DW-1:0] last_data = '0;
    logic prev_valid = 1'b0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (wr_valid_o) begin
            pulse_cnt = pulse_cnt + 1;
            last_cyc  = cyc;
            last_addr = wr_addr_o;
            last_data = wr_data_o;
            if (prev_valid) wide = wide + 1;
        end
        if (wr_valid_o && cmd_rst_o) overlap = overlap + 1;
        prev_valid = wr_valid_o;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // full write, release of ce or we first; returns cycle of first sampling edge
    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input bit rel_ce, output int t_rel);
        @(negedge clk);
        addr_i = a; data_i = d; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
        repeat (N + 3) @(negedge clk);
        if (rel_ce) ce_n = 1'b1; else we_n = 1'b1;
        t_rel = cyc + 1;
        repeat (N + 6) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        idle(N + 4);
    endtask

    task automatic hold_combo(input logic c, input logic w, input logic o, input int len);
        @(negedge clk);
        ce_n = c; we_n = w; oe_n = o;
        repeat (len) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        idle(N + 6);
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 200000);
        finish_run();
    end

    initial begin
        int p0, t;
        repeat (3) @(negedge clk);
        #1;
        check(wr_valid_o == 1'b0, "R5 reset valid", wr_valid_o, 0);
        check(cmd_rst_o == 1'b1, "R6 reset cmd_rst", cmd_rst_o, 1);
        @(negedge clk); rst_n = 1'b1;
        idle(N + 6);
        check(cmd_rst_o == 1'b0, "R6 cmd_rst released", cmd_rst_o, 0);

        // R2 R4 R5: release on we, then on ce
        for (int r = 0; r < 2; r++) begin
            p0 = pulse_cnt;
            do_write(8'h3C + 8'(r), 8'hA5 ^ 8'(r), r[0], t);
            check(pulse_cnt - p0 == 1, "R2 one commit", pulse_cnt - p0, 1);
            check(last_cyc == t + N + 2, "R4 latency", last_cyc, t + N + 2);
            check(last_addr == 8'h3C + 8'(r), "R2 address", last_addr, 8'h3C + r);
            check(last_data == (8'hA5 ^ 8'(r)), "R2 data", last_data, 8'hA5 ^ r);
        end

        // R1: sweep all strobe combinations
        for (int c = 0; c < 8; c++) begin
            int exp;
            exp = (c[2] == 0 && c[1] == 0 && c[0] == 1) ? 1 : 0;
            p0 = pulse_cnt;
            hold_combo(c[2], c[1], c[0], N + 4);
            check(pulse_cnt - p0 == exp, "R1 combination", pulse_cnt - p0, exp);
        end

        // R3: low pulse width sweep
        for (int w = 1; w <= N + 1; w++) begin
            int exp;
            exp = (w >= N) ? 1 : 0;
            p0 = pulse_cnt;
            hold_combo(1'b0, 1'b0, 1'b1, w);
            check(pulse_cnt - p0 == exp, "R3 low pulse width", pulse_cnt - p0, exp);
        end

        // R3: high interruption width sweep inside a write
        for (int w = 1; w <= N; w++) begin
            int exp;
            exp = (w >= N) ? 2 : 1;
            p0 = pulse_cnt;
            @(negedge clk);
            addr_i = 8'h55; data_i = 8'h66; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
            repeat (N + 3) @(negedge clk);
            we_n = 1'b1;
            repeat (w) @(negedge clk);
            we_n = 1'b0;
            repeat (N + 3) @(negedge clk);
            we_n = 1'b1;
            repeat (N + 6) @(negedge clk);
            ce_n = 1'b1;
            idle(N + 4);
            check(pulse_cnt - p0 == exp, "R3 high glitch", pulse_cnt - p0, exp);
        end

        // R9: output enable low during a write aborts it
        p0 = pulse_cnt;
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
        repeat (N + 3) @(negedge clk);
        oe_n = 1'b0;
        repeat (N + 3) @(negedge clk);
        we_n = 1'b1;
        repeat (N + 6) @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
        idle(N + 4);
        check(pulse_cnt - p0 == 0, "R9 oe abort", pulse_cnt - p0, 0);

        // R6 R7: lockout during a write, then supply return with strobes low
        p0 = pulse_cnt;
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
        repeat (N + 3) @(negedge clk);
        supply_ok = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        check(cmd_rst_o == 1'b0, "R6 cmd_rst not early", cmd_rst_o, 0);
        @(negedge clk); #1;
        check(cmd_rst_o == 1'b1, "R6 cmd_rst timing", cmd_rst_o, 1);
        we_n = 1'b1;
        repeat (N + 6) @(negedge clk);
        #1;
        check(pulse_cnt - p0 == 0, "R6 no write in lockout", pulse_cnt - p0, 0);
        we_n = 1'b0;
        repeat (N + 3) @(negedge clk);
        supply_ok = 1'b1;
        repeat (N + 6) @(negedge clk);
        #1;
        check(cmd_rst_o == 1'b0, "R6 cmd_rst released", cmd_rst_o, 0);
        we_n = 1'b1;
        repeat (N + 6) @(negedge clk);
        ce_n = 1'b1;
        idle(N + 4);
        check(pulse_cnt - p0 == 0, "R7 inhibit after lockout", pulse_cnt - p0, 0);
        do_write(8'h81, 8'h18, 1'b0, t);
        check(pulse_cnt - p0 == 1, "R7 write after requalify", pulse_cnt - p0, 1);

        // R8: reset released with ce and we low
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (N + 8) @(negedge clk);
        p0 = pulse_cnt;
        we_n = 1'b1;
        repeat (N + 6) @(negedge clk);
        ce_n = 1'b1;
        idle(N + 4);
        check(pulse_cnt - p0 == 0, "R8 power-up rise ignored", pulse_cnt - p0, 0);
        do_write(8'hE7, 8'h7E, 1'b0, t);
        check(pulse_cnt - p0 == 1, "R8 next write accepted", pulse_cnt - p0, 1);
        check(last_addr == 8'hE7, "R8 address", last_addr, 8'hE7);

        check(wide == 0, "R5 pulse width", wide, 0);
        check(overlap == 0, "R10 valid with cmd_rst", overlap, 0);
        finish_run();
    end
endmodule